// File: doc/BRIEF.md
# Piecewise-Linear Flip Term Generator

This block turns a uniform random fraction into the noise term that an annealing solver adds to a spin's local field before it decides the spin's next state. The ideal term is T·ln(1/r − 1). The block approximates the logarithm with three straight lines whose slopes are powers of two, so every product is a fixed shift. The segment is chosen by comparing r against the one-eighth and seven-eighths points. The line value is captured in a register, and that captured value is then scaled by 2^e, where e is the current temperature exponent.

The fraction r is an unsigned number with `R_FRAC_W` fractional bits. The output is a two's complement value with the same number of fractional bits, so one output LSB equals 2^-R_FRAC_W. A small schedule counter holds each temperature exponent for `LEVEL_HOLD` accepted samples and then lowers it by one until it reaches zero. A restart pulse puts the exponent back at its highest value. By default the output is wide enough that no scaled line value can overflow. When `OUT_W` is set narrower, the output clamps at its limits instead of wrapping.

Top module: `fterm_gen`

## Requirements
- R1: For 0 < r < 0.125 (the top three bits of r are 000), the output is (4.875 − 32·r)·2^e, where e is the exponent in effect when r was sampled.
- R2: For 0.125 ≤ r ≤ 0.875 (0.875 exactly included, even though its top three bits are 111), the output is (2 − 4·r)·2^e.
- R3: For r > 0.875, the output is (27.125 − 32·r)·2^e.
- R4: r = 0 gives the most positive output code, 2^(OUT_W−1) − 1, whatever the exponent.
- R5: The segment value is multiplied by 2^e, using the exponent shown on `temp_exp` during the cycle in which r is sampled.
- R6: `flip_valid` is high in exactly the cycle after a cycle with `r_valid` high. When `r_valid` is low, `flip_term` holds its previous value.
- R7: If the scaled value lies outside the `OUT_W` range, the output is clamped to 2^(OUT_W−1) − 1 or −2^(OUT_W−1). It never wraps, and its sign always matches the sign of the segment value.
- R8: After reset, `temp_exp` equals `T_MAX_EXP`, `flip_valid` is low and `flip_term` is zero.
- R9: Each exponent value is kept for `LEVEL_HOLD` accepted samples and then falls by exactly one. Once it reaches zero it stays at zero. Without a restart it never rises.
- R10: A `sched_restart` pulse sets the exponent back to `T_MAX_EXP` and clears the hold count. A sample taken in the same cycle uses the exponent from before the restart and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_restart | input | 1 | Restarts the temperature schedule at the highest exponent |
| r_valid | input | 1 | r_frac is sampled in this cycle |
| r_frac | input | R_FRAC_W | Unsigned random fraction, all bits fractional |
| flip_valid | output | 1 | flip_term holds a fresh result |
| flip_term | output | OUT_W | Signed flip term, R_FRAC_W fractional bits |
| temp_exp | output | EXP_W | Current temperature exponent |

## Verification
The bench aims at the segment edges: 1 LSB, the last code below one eighth, one eighth itself, exactly seven eighths, one LSB above seven eighths, and the all-ones code. A selector that decoded only the top three bits would give −0.875 instead of −1.5 at exactly seven eighths. A mistake in a constant or a shift would move a whole segment by a fixed offset. The zero input must give the saturated maximum, not 4.875. A second, narrower instance checks that large scaled values clamp and do not wrap into the opposite sign. The exponent is tracked across level boundaries, down to the floor at zero, and through restarts that land on the same cycle as a sample, where an off-by-one in the hold count or the wrong exponent choice shows up at once.

// File: rtl/fterm_pkg.sv
package fterm_pkg;

   // Which line of the approximation a sample falls on
   typedef enum logic [1:0] {
      SEG_ZERO = 2'd0,
      SEG_LOW  = 2'd1,
      SEG_MID  = 2'd2,
      SEG_HIGH = 2'd3
   } seg_sel_e;

   // Extra integer bits (sign plus five) carried by a segment value
   localparam int SEG_INT_W = 6;

endpackage

// File: rtl/fterm_segment.sv
module fterm_segment
   import fterm_pkg::*;
#(
   parameter int R_FRAC_W = 16
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [R_FRAC_W-1:0]                   r_frac,
   output seg_sel_e                              sel,
   output logic signed [R_FRAC_W+SEG_INT_W-1:0]  seg_val
);

   localparam int SW = R_FRAC_W + SEG_INT_W;
   localparam int EIGHTH_SH = R_FRAC_W - 3;

   // Line offsets in units of 2^-R_FRAC_W
   localparam logic signed [SW-1:0] K_LOW  = SW'(39)  << EIGHTH_SH;  // 4.875
   localparam logic signed [SW-1:0] K_MID  = SW'(2)   << R_FRAC_W;   // 2.0
   localparam logic signed [SW-1:0] K_HIGH = SW'(217) << EIGHTH_SH;  // 27.125
   localparam logic [R_FRAC_W-1:0]  R_UPPER = R_FRAC_W'(7) << EIGHTH_SH;
   localparam logic signed [SW-1:0] MID_LIM = SW'(3) << (R_FRAC_W - 1);

   generate
      if (R_FRAC_W < 4) begin : g_bad_width
         $error("fterm_segment: R_FRAC_W must be at least 4");
      end
   endgenerate

   logic signed [SW-1:0] r_ext;
   logic signed [SW-1:0] r_x32;
   logic signed [SW-1:0] r_x4;
   logic [2:0]           top3;

   assign r_ext = $signed({{SEG_INT_W{1'b0}}, r_frac});
   assign r_x32 = r_ext <<< 5;
   assign r_x4  = r_ext <<< 2;
   assign top3  = r_frac[R_FRAC_W-1 -: 3];

   always_comb begin
      if (r_frac == '0)
         sel = SEG_ZERO;
      else if (top3 == 3'b000)
         sel = SEG_LOW;
      else if (r_frac > R_UPPER)
         sel = SEG_HIGH;
      else
         sel = SEG_MID;
   end

   always_comb begin
      unique case (sel)
         SEG_LOW:  seg_val = K_LOW - r_x32;
         SEG_MID:  seg_val = K_MID - r_x4;
         SEG_HIGH: seg_val = K_HIGH - r_x32;
         default:  seg_val = K_LOW;
      endcase
   end

   // R1: the low line stays positive over its span
   a_r1_low_positive: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEG_LOW) |-> (seg_val > 0));

   // R2: the middle line stays within +/-1.5
   a_r2_mid_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEG_MID) |-> (seg_val <= MID_LIM && seg_val >= -MID_LIM));

   // R3: the high line stays negative over its span
   a_r3_high_negative: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEG_HIGH) |-> (seg_val < 0));

endmodule

// File: rtl/fterm_sched.sv
module fterm_sched #(
   parameter int T_MAX_EXP  = 7,
   parameter int LEVEL_HOLD = 256,
   parameter int EXP_W      = $clog2(T_MAX_EXP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   output logic [EXP_W-1:0] exp_cur
);

   localparam int HW = (LEVEL_HOLD > 1) ? $clog2(LEVEL_HOLD) : 1;
   localparam logic [HW-1:0]    HOLD_LAST = HW'(LEVEL_HOLD - 1);
   localparam logic [EXP_W-1:0] EXP_TOP   = EXP_W'(T_MAX_EXP);

   generate
      if (T_MAX_EXP < 1) begin : g_bad_tmax
         $error("fterm_sched: T_MAX_EXP must be at least 1");
      end
      if (LEVEL_HOLD < 1) begin : g_bad_hold
         $error("fterm_sched: LEVEL_HOLD must be at least 1");
      end
      if (EXP_W < $clog2(T_MAX_EXP + 1)) begin : g_bad_expw
         $error("fterm_sched: EXP_W too narrow for T_MAX_EXP");
      end
   endgenerate

   logic [HW-1:0] hold_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_cur  <= EXP_TOP;
         hold_cnt <= '0;
      end else if (restart) begin
         exp_cur  <= EXP_TOP;
         hold_cnt <= '0;
      end else if (step) begin
         if (hold_cnt == HOLD_LAST) begin
            hold_cnt <= '0;
            if (exp_cur != '0)
               exp_cur <= exp_cur - 1'b1;
         end else begin
            hold_cnt <= hold_cnt + 1'b1;
         end
      end
   end

   // R9: the exponent never rises except through a restart
   a_r9_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> (exp_cur <= $past(exp_cur)));

   // R9: the exponent moves by at most one per cycle
   a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> (exp_cur == $past(exp_cur) || exp_cur == $past(exp_cur) - 1'b1));

   // R9: without a step the exponent is unchanged
   a_r9_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !step) |=> $stable(exp_cur));

   // R10: a restart puts the exponent back at its top value
   a_r10_restart_top: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (exp_cur == EXP_TOP));

endmodule

// File: rtl/fterm_scale.sv
module fterm_scale #(
   parameter int R_FRAC_W  = 16,
   parameter int T_MAX_EXP = 7,
   parameter int OUT_W     = R_FRAC_W + 6 + T_MAX_EXP,
   parameter int EXP_W     = $clog2(T_MAX_EXP + 1)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic signed [R_FRAC_W+5:0]          seg_val,
   input  logic [EXP_W-1:0]                    exp_val,
   input  logic                                is_zero,
   output logic signed [OUT_W-1:0]             term
);

   localparam int SW     = R_FRAC_W + 6;
   localparam int FULL_W = SW + T_MAX_EXP;
   localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (OUT_W < R_FRAC_W + 2) begin : g_bad_outw
         $error("fterm_scale: OUT_W must exceed R_FRAC_W by at least 2");
      end
   endgenerate

   logic signed [FULL_W-1:0] seg_x;
   logic signed [FULL_W-1:0] wide;
   logic signed [OUT_W-1:0]  fitted;

   assign seg_x = {{T_MAX_EXP{seg_val[SW-1]}}, seg_val};
   assign wide  = seg_x <<< exp_val;

   generate
      if (OUT_W >= FULL_W) begin : g_wide_out
         // Every scaled value fits: plain sign extension
         assign fitted = OUT_W'(wide);
      end else begin : g_clamp_out
         localparam logic signed [FULL_W-1:0] LIM_HI = FULL_W'(OUT_MAX);
         localparam logic signed [FULL_W-1:0] LIM_LO = FULL_W'(OUT_MIN);
         always_comb begin
            if (wide > LIM_HI)
               fitted = OUT_MAX;
            else if (wide < LIM_LO)
               fitted = OUT_MIN;
            else
               fitted = OUT_W'(wide);
         end
      end
   endgenerate

   assign term = is_zero ? OUT_MAX : fitted;

   // R7: scaling and clamping keep the sign of the segment value
   a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_zero && seg_val != 0) |-> (term[OUT_W-1] == seg_val[SW-1] && term != 0));

endmodule

// File: rtl/fterm_gen.sv
module fterm_gen
   import fterm_pkg::*;
#(
   parameter int R_FRAC_W   = 16,
   parameter int T_MAX_EXP  = 7,
   parameter int LEVEL_HOLD = 256,
   parameter int OUT_W      = R_FRAC_W + SEG_INT_W + T_MAX_EXP,
   parameter int EXP_W      = $clog2(T_MAX_EXP + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sched_restart,
   input  logic                       r_valid,
   input  logic [R_FRAC_W-1:0]        r_frac,
   output logic                       flip_valid,
   output logic signed [OUT_W-1:0]    flip_term,
   output logic [EXP_W-1:0]           temp_exp
);

   localparam int SW = R_FRAC_W + SEG_INT_W;
   localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};

   seg_sel_e             seg_sel;
   logic signed [SW-1:0] seg_val;
   logic signed [SW-1:0] seg_q;
   logic [EXP_W-1:0]     exp_q;
   logic                 zero_q;
   logic                 vld_q;

   fterm_segment #(.R_FRAC_W(R_FRAC_W)) u_seg (
      .clk     (clk),
      .rst_n   (rst_n),
      .r_frac  (r_frac),
      .sel     (seg_sel),
      .seg_val (seg_val)
   );

   fterm_sched #(
      .T_MAX_EXP  (T_MAX_EXP),
      .LEVEL_HOLD (LEVEL_HOLD),
      .EXP_W      (EXP_W)
   ) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (sched_restart),
      .step    (r_valid),
      .exp_cur (temp_exp)
   );

   // Staging register: segment value, its exponent and the zero flag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q  <= '0;
         exp_q  <= '0;
         zero_q <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= r_valid;
         if (r_valid) begin
            seg_q  <= seg_val;
            exp_q  <= temp_exp;
            zero_q <= (seg_sel == SEG_ZERO);
         end
      end
   end

   fterm_scale #(
      .R_FRAC_W  (R_FRAC_W),
      .T_MAX_EXP (T_MAX_EXP),
      .OUT_W     (OUT_W),
      .EXP_W     (EXP_W)
   ) u_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .seg_val (seg_q),
      .exp_val (exp_q),
      .is_zero (zero_q),
      .term    (flip_term)
   );

   assign flip_valid = vld_q;

   // R6: a sample produces a valid result one cycle later
   a_r6_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |=> flip_valid);

   // R6: no sample, no valid
   a_r6_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
      !r_valid |=> !flip_valid);

   // R6: the term holds while no sample arrives
   a_r6_term_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !r_valid |=> $stable(flip_term));

   // R4: a zero fraction yields the top output code
   a_r4_zero_max: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && r_frac == '0) |=> (flip_term == OUT_MAX));

endmodule

// File: tb/sim_fterm_gen.sv
`timescale 1ns/1ps
module sim_fterm_gen;

   localparam int RW  = 16;
   localparam int TM  = 3;
   localparam int HL  = 5;
   localparam int OW0 = RW + 6 + TM;
   localparam int OW1 = RW + 4;
   localparam int EW  = 2;
   localparam longint E8 = longint'(1) << (RW - 3);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sched_restart = 1'b0;
   logic r_valid = 1'b0;
   logic [RW-1:0] r_frac = '0;
   logic v0, v1;
   logic signed [OW0-1:0] t0;
   logic signed [OW1-1:0] t1;
   logic [EW-1:0] e0, e1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int m_exp = TM;
   int m_cnt = 0;

   always #10 clk = ~clk;

   fterm_gen #(.R_FRAC_W(RW), .T_MAX_EXP(TM), .LEVEL_HOLD(HL)) u0 (
      .clk(clk), .rst_n(rst_n), .sched_restart(sched_restart), .r_valid(r_valid),
      .r_frac(r_frac), .flip_valid(v0), .flip_term(t0), .temp_exp(e0));

   fterm_gen #(.R_FRAC_W(RW), .T_MAX_EXP(TM), .LEVEL_HOLD(HL), .OUT_W(OW1)) u1 (
      .clk(clk), .rst_n(rst_n), .sched_restart(sched_restart), .r_valid(r_valid),
      .r_frac(r_frac), .flip_valid(v1), .flip_term(t1), .temp_exp(e1));

   function automatic longint seg_model(longint r);
      if ((r >> (RW - 3)) == 0) return 39 * E8 - 32 * r;
      else if (r > 7 * E8)      return 217 * E8 - 32 * r;
      else                      return 2 * (longint'(1) << RW) - 4 * r;
   endfunction

   function automatic longint term_model(longint r, int e, int ow);
      longint hi, lo, v;
      hi = (longint'(1) << (ow - 1)) - 1;
      lo = -(longint'(1) << (ow - 1));
      if (r == 0) return hi;
      v = seg_model(r) * (longint'(1) << e);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic string req_of(longint r);
      if (r == 0) return "R4";
      if ((r >> (RW - 3)) == 0) return "R1";
      if (r > 7 * E8) return "R3";
      return "R2";
   endfunction

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic sample(longint r, bit rs);
      int e_used;
      longint x0, x1;
      @(negedge clk);
      r_valid = 1'b1;
      r_frac = RW'(r);
      sched_restart = rs;
      e_used = m_exp;
      if (rs) begin
         m_exp = TM; m_cnt = 0;
      end else if (m_cnt == HL - 1) begin
         m_cnt = 0;
         if (m_exp > 0) m_exp--;
      end else begin
         m_cnt++;
      end
      @(negedge clk);
      r_valid = 1'b0;
      sched_restart = 1'b0;
      x0 = term_model(r, e_used, OW0);
      x1 = term_model(r, e_used, OW1);
      check("R6", "valid after sample", longint'(v0), 1);
      check({req_of(r), "/R5"}, "wide term", longint'(t0), x0);
      check((x1 != x0) ? "R7" : req_of(r), "narrow term", longint'(t1), x1);
      check(rs ? "R10" : "R9", "exponent", longint'(e0), longint'(m_exp));
   endtask

   task automatic idle_check();
      longint keep;
      keep = longint'(t0);
      @(negedge clk);
      check("R6", "valid while idle", longint'(v0), 0);
      check("R6", "term held while idle", longint'(t0), keep);
      check("R9", "exponent held while idle", longint'(e0), longint'(m_exp));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check("R8", "valid in reset", longint'(v0), 0);
      check("R8", "term in reset", longint'(t0), 0);
      check("R8", "exponent in reset", longint'(e0), TM);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", "valid after reset", longint'(v0), 0);

      // Directed segment edges at the top exponent
      sample(1, 1'b0);
      sample(E8 - 1, 1'b0);
      sample(E8, 1'b0);
      sample(7 * E8, 1'b0);
      sample(7 * E8 + 1, 1'b0);
      idle_check();
      sample((longint'(1) << RW) - 1, 1'b0);
      sample(0, 1'b0);
      sample(longint'(1) << (RW - 1), 1'b0);
      // Restart in the same cycle as a sample
      sample(3 * E8, 1'b1);
      // Walk the schedule down to the floor and beyond
      for (int i = 0; i < 4 * HL + 3; i++) sample(longint'(i) * 911 + 1, 1'b0);
      check("R9", "floor exponent", longint'(e0), 0);
      sample(0, 1'b0);
      sample(7 * E8, 1'b1);
      idle_check();

      // Random stimulus with sparse restarts and a few edge values
      for (int i = 0; i < 200; i++) begin
         longint r;
         int pick;
         pick = $urandom_range(0, 9);
         if (pick == 0)      r = 0;
         else if (pick == 1) r = 7 * E8 + $urandom_range(0, 1);
         else if (pick == 2) r = E8 - $urandom_range(0, 1);
         else                r = longint'($urandom_range(0, (1 << RW) - 1));
         sample(r, ($urandom_range(0, 39) == 0));
         if ($urandom_range(0, 7) == 0) idle_check();
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule